// File: doc/BRIEF.md
# Range-Based Interrupt Number Translator

This block converts a local interrupt pin number into the matching interrupt number of a parent controller. Software loads a small table. Each entry describes one contiguous run of pins: the first local pin of the run, the parent number that pin maps to, and how many pins the run covers. A request presents a pin and a valid strobe. One cycle later the block returns the translated parent number, together with a hit flag and an error flag.

Entries are compared in parallel, and the entry with the lowest index takes priority. When no entry covers the pin, the block raises the error flag and drives the parent number to zero, so the raw pin never appears as a parent number. Pins at or above the pin limit are always rejected. Table writes go one entry at a time through a simple write port.

Top module: `irq_xlate`

## Requirements
- R1: After reset every table entry has count 0, and the response outputs (rsp_valid_o, rsp_hit_o, rsp_err_o, rsp_parent_o) are all 0.
- R2: Entry k matches pin p exactly when base_k <= p < base_k + count_k. An entry whose count is 0 never matches.
- R3: On a match, rsp_parent_o equals parent_k + (p - base_k), taken from the matching entry k.
- R4: When no entry matches, rsp_err_o is 1, rsp_hit_o is 0 and rsp_parent_o is 0. The raw pin is never passed out as a parent number.
- R5: When several entries match, the one with the lowest index wins.
- R6: rsp_valid_o is 1 exactly one cycle after req_valid_i was 1, and the response reflects the request sampled in that cycle. When rsp_valid_o is 0, rsp_hit_o and rsp_err_o are 0. When rsp_valid_o is 1, exactly one of rsp_hit_o and rsp_err_o is 1.
- R7: A pin at or above PIN_LIMIT (default 126) yields an error, even if some range would cover it.
- R8: A table write (wr_en_i, wr_idx_i, wr_base_i, wr_parent_i, wr_count_i) in the same cycle as a request does not affect that request. The written entry is used from the next request on.
- R9: Using the ranges 0→512 with count 94, 94→641 with count 15 and 115→662 with count 7, pin 2 gives 514, pin 93 gives 605, pin 94 gives 641, pin 108 gives 655, pin 115 gives 662 and pin 121 gives 668. Pins 109..114 and pin 122 give errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 3 | Entry index to write |
| wr_base_i | input | 7 | First local pin of the range |
| wr_parent_i | input | 10 | Parent number for the first pin |
| wr_count_i | input | 7 | Number of pins in the range |
| req_valid_i | input | 1 | Lookup request strobe |
| req_pin_i | input | 7 | Local pin to translate |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | Translation found |
| rsp_err_o | output | 1 | No entry covers the pin, or the pin is out of range |
| rsp_parent_o | output | 10 | Translated parent number, 0 on error |

## Verification
The bench checks the range edges from both sides: the first pin of a range, the last pin, and the pin just past the last. A design with an off-by-one in the upper compare would translate pin 109 or reject pin 108. A zero-count entry placed over an active range must not match; a design that treats count 0 as "all pins" would claim the pin. Overlapping entries check the lowest-index priority, which an inverted priority encoder would get wrong. A write that lands in the same cycle as a request checks that the lookup sees the table from before the write. A design that bypassed the write data into the compare would answer that request with the new mapping. A miss must return a zero parent number, so any pass-through of the pin shows up on rsp_parent_o.

// File: rtl/irq_xlate_pkg.sv
package irq_xlate_pkg;
  localparam int unsigned PIN_W    = 7;
  localparam int unsigned PARENT_W = 10;

  typedef struct packed {
    logic [PIN_W-1:0]    base;
    logic [PARENT_W-1:0] parent;
    logic [PIN_W-1:0]    count;
  } range_t;
endpackage

// File: rtl/irq_xlate_table.sv
module irq_xlate_table
  import irq_xlate_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  range_t              wr_entry_i,
  output range_t              tbl_o [ENTRIES]
);
  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        tbl_o[k] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(k)))
        tbl_o[k] <= wr_entry_i;
    end
  end

`ifndef SYNTHESIS
  // R1
  reset_empty_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (tbl_o[0].count == '0));
`endif
endmodule

// File: rtl/irq_xlate_match.sv
module irq_xlate_match
  import irq_xlate_pkg::*;
#(
  parameter int unsigned ENTRIES   = 8,
  parameter int unsigned PIN_LIMIT = 126
) (
  input  range_t               tbl_i [ENTRIES],
  input  logic [PIN_W-1:0]     pin_i,
  output logic                 hit_o,
  output logic [PARENT_W-1:0]  parent_o
);
  logic [ENTRIES-1:0] match;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_cmp
    logic [PIN_W:0] top;
    assign top      = {1'b0, tbl_i[k].base} + {1'b0, tbl_i[k].count};
    assign match[k] = (tbl_i[k].count != '0) &&
                      (pin_i >= tbl_i[k].base) &&
                      ({1'b0, pin_i} < top);
  end

  // Lowest index wins: scan from the top so lower indices overwrite.
  always_comb begin
    hit_o    = 1'b0;
    parent_o = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o    = 1'b1;
        parent_o = tbl_i[k].parent + PARENT_W'(pin_i - tbl_i[k].base);
      end
    end
    if (32'(pin_i) >= PIN_LIMIT) begin
      hit_o    = 1'b0;
      parent_o = '0;
    end
  end
endmodule

// File: rtl/irq_xlate.sv
module irq_xlate
  import irq_xlate_pkg::*;
#(
  parameter int unsigned ENTRIES   = 8,
  parameter int unsigned PIN_LIMIT = 126,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [PIN_W-1:0]    wr_base_i,
  input  logic [PARENT_W-1:0] wr_parent_i,
  input  logic [PIN_W-1:0]    wr_count_i,
  input  logic                req_valid_i,
  input  logic [PIN_W-1:0]    req_pin_i,
  output logic                rsp_valid_o,
  output logic                rsp_hit_o,
  output logic                rsp_err_o,
  output logic [PARENT_W-1:0] rsp_parent_o
);
  range_t              tbl [ENTRIES];
  range_t              wr_entry;
  logic                lk_hit;
  logic [PARENT_W-1:0] lk_parent;

  assign wr_entry = '{base: wr_base_i, parent: wr_parent_i, count: wr_count_i};

  irq_xlate_table #(.ENTRIES(ENTRIES)) u_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i,
    .wr_entry_i(wr_entry), .tbl_o(tbl)
  );

  irq_xlate_match #(.ENTRIES(ENTRIES), .PIN_LIMIT(PIN_LIMIT)) u_match (
    .tbl_i(tbl), .pin_i(req_pin_i), .hit_o(lk_hit), .parent_o(lk_parent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_err_o    <= 1'b0;
      rsp_parent_o <= '0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_hit_o    <= req_valid_i & lk_hit;
      rsp_err_o    <= req_valid_i & ~lk_hit;
      rsp_parent_o <= (req_valid_i & lk_hit) ? lk_parent : '0;
    end
  end

`ifndef SYNTHESIS
  // R6
  rsp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R6
  rsp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_err_o}) == 1);
  // R6
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_hit_o && !rsp_err_o);
  // R4
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_parent_o == '0);
  // R7
  pin_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && 32'(req_pin_i) >= PIN_LIMIT) |=> rsp_err_o);
`endif
endmodule

// File: tb/irq_xlate_test.sv
module irq_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_idx_i = '0;
  logic [6:0] wr_base_i = '0;
  logic [9:0] wr_parent_i = '0;
  logic [6:0] wr_count_i = '0;
  logic       req_valid_i = 1'b0;
  logic [6:0] req_pin_i = '0;
  logic       rsp_valid_o, rsp_hit_o, rsp_err_o;
  logic [9:0] rsp_parent_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  irq_xlate uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // pin, hit, parent
  localparam int NV = 14;
  localparam int VEC [NV][3] = '{
    '{2, 1, 514}, '{0, 1, 512}, '{93, 1, 605}, '{94, 1, 641},
    '{108, 1, 655}, '{109, 0, 0}, '{114, 0, 0}, '{115, 1, 662},
    '{121, 1, 668}, '{122, 0, 0}, '{111, 0, 0}, '{50, 1, 562},
    '{125, 0, 0}, '{127, 0, 0}};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int idx, int b, int p, int c);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 3'(idx); wr_base_i = 7'(b);
    wr_parent_i = 10'(p); wr_count_i = 7'(c);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  // Issue request at a negedge, sample at the following negedge.
  task automatic look(int pin, string req, int ehit, int epar);
    @(negedge clk_i);
    req_valid_i = 1; req_pin_i = 7'(pin);
    @(negedge clk_i);
    req_valid_i = 0;
    check({req, " valid"}, rsp_valid_o, 1);
    check({req, " hit"}, rsp_hit_o, ehit);
    check({req, " err"}, rsp_err_o, !ehit);
    check({req, " parent"}, rsp_parent_o, epar);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 valid", rsp_valid_o, 0);
    check("R1 hit", rsp_hit_o, 0);
    check("R1 err", rsp_err_o, 0);
    check("R1 parent", rsp_parent_o, 0);
    rst_ni = 1;
    // R1: empty table misses
    look(2, "R1 empty", 0, 0);

    wr(0, 0, 512, 94);
    wr(1, 94, 641, 15);
    wr(2, 115, 662, 7);
    for (int i = 0; i < NV; i++)
      look(VEC[i][0], $sformatf("R9/R3/R4 pin%0d", VEC[i][0]), VEC[i][1], VEC[i][2]);

    // R6 no response without request
    @(negedge clk_i);
    check("R6 idle valid", rsp_valid_o, 0);
    check("R6 idle err", rsp_err_o, 0);

    // R2 zero count never matches: entry 3 covers pin 112 with count 0
    wr(3, 110, 900, 0);
    look(112, "R2 zero count", 0, 0);
    // R2/R3 upper edge of entry 3 once sized
    wr(3, 110, 900, 3);
    look(112, "R2 last", 1, 902);
    look(113, "R2 past end", 0, 0);

    // R5 overlap: entry 4 covers 0..9 but entry 0 wins
    wr(4, 0, 100, 10);
    look(5, "R5 lowest index", 1, 517);
    // lower index 3 vs higher 4: entry 5 overlaps entry 3
    wr(5, 110, 300, 2);
    look(110, "R5 overlap 3v5", 1, 900);

    // R7: range covering pins 124..127 still rejects >= 126
    wr(6, 124, 700, 4);
    look(125, "R7 inside", 1, 701);
    look(126, "R7 limit", 0, 0);

    // R8: write in same cycle as request
    @(negedge clk_i);
    req_valid_i = 1; req_pin_i = 7'd120;
    wr_en_i = 1; wr_idx_i = 3'd2; wr_base_i = 7'd115;
    wr_parent_i = 10'd20; wr_count_i = 7'd7;
    @(negedge clk_i);
    req_valid_i = 0; wr_en_i = 0;
    check("R8 old map", rsp_parent_o, 667);
    look(120, "R8 new map", 1, 25);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule